// File: doc/BRIEF.md
# USB PHY Control Register Bank

This block is the register file that software uses to configure a USB 2.0 PHY. It sits on a simple 32-bit bus with a byte address, a write strobe and write data, and it returns read data combinationally from the address. It holds three registers: a power-down word with one bit per PHY section, a transmit calibration word with three 4-bit trim fields, and a control word with the soft reset, the clock gate, the automatic clock and power enables, the wakeup source enables, the speed support levels and the host disconnect detect enable. Every field drives a level output towards the rest of the PHY.

Each register can be updated three ways. A write to its base offset replaces it. A write to base+4 ORs the data into it. A write to base+8 clears the bits that are 1 in the data. Because of the two aliases, driver code can change one field without a read-modify-write sequence. The soft reset bit in the control word puts the whole bank back to its defaults and holds it there for as long as the bit stays set.

Top module: `usbphy_regbank`

## Requirements
- R1: After rst_n is released the power-down register reads 0xFFFF_FFFF, the transmit calibration register reads 0 and the control register reads 0x4000_0000 (clock gate set, everything else clear).
- R2: A write to offset 0x00, 0x10 or 0x30 replaces that register with the write data, limited to its implemented bits: all 32 for power-down, mask 0x000F_0F0F for transmit calibration, and mask 0xC6FC_C002 for control. A read of the same offset returns the stored value, and unimplemented bits read 0. The update is visible from the clock edge that takes the write.
- R3: A write to base+4 (0x04, 0x14, 0x34) ORs the masked write data into the register.
- R4: A write to base+8 (0x08, 0x18, 0x38) clears every register bit whose write data bit is 1 and leaves all the others unchanged.
- R5: If a write leaves control bit 31 (soft reset) at 1, every other bit of the bank takes its R1 value on that same edge. While bit 31 stays 1, writes that do not clear it change nothing else in the bank.
- R6: A write that clears control bit 31 releases the bank. Every field in that write takes effect, and later writes behave as in R2 to R4.
- R7: Control bits drive outputs as follows: 31 soft reset, 30 clock gate, 26 automatic USB clock enable, 25 automatic clear of the USB clock gate, 23 wake on VBUS change, 22 wake on ID change, 21 wake on DP/DM change, 20 automatic clear of power-down, 19 automatic clear of the clock gate, 18 automatic PLL power-on, 15 low-speed level, 14 full-speed level, 1 host disconnect detect.
- R8: The transmit calibration fields drive three 4-bit outputs: bits 19:16 for the DP termination trim, 11:8 for the DM termination trim and 3:0 for the drive current trim.
- R9: Reads of any offset other than 0x00, 0x10 and 0x30 return 0, including the set and clear aliases. Writes to any offset outside the nine register and alias offsets leave the whole bank unchanged.
- R10: The power-down output always equals the power-down register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pwr_down_o | output | 32 | Section power-down levels |
| tx_term_p_o | output | 4 | DP termination trim |
| tx_term_n_o | output | 4 | DM termination trim |
| tx_drive_o | output | 4 | Drive current trim |
| ctl_soft_reset_o | output | 1 | Soft reset level |
| ctl_clk_gate_o | output | 1 | Clock gate level |
| ctl_auto_usbclk_o | output | 1 | Automatic USB clock enable |
| ctl_auto_clr_usbgate_o | output | 1 | Automatic clear of USB clock gate |
| ctl_wake_vbus_o | output | 1 | Wake on VBUS change |
| ctl_wake_id_o | output | 1 | Wake on ID change |
| ctl_wake_line_o | output | 1 | Wake on DP/DM change |
| ctl_auto_clr_pwd_o | output | 1 | Automatic clear of power-down |
| ctl_auto_clr_gate_o | output | 1 | Automatic clear of clock gate |
| ctl_auto_pll_on_o | output | 1 | Automatic PLL power-on |
| ctl_ls_level_o | output | 1 | Low-speed support level |
| ctl_fs_level_o | output | 1 | Full-speed support level |
| ctl_host_disc_o | output | 1 | Host disconnect detect enable |

## Verification
Every register goes through a walking-one sweep at its plain, set and clear offsets. The plain sweep tells replacement apart from accumulation, the set sweep shows that earlier bits survive, and the clear sweep removes single bits from a register that is otherwise full, so a swapped or mis-masked alias shows up at once. Alternating 0xA5 and 0x5A words separate the fields from each other and from the unimplemented holes. When the sweep reaches bit 31 of the control word it enters soft reset, which tests the hold on the other registers and the release by a later clear. Finally a write of all ones and a read at each of the other 247 addresses tells unmapped offsets apart from aliased ones.

// File: rtl/usbphy_regbank_pkg.sv
package usbphy_regbank_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 3;

    localparam int IDX_PWD = 0;
    localparam int IDX_TX  = 1;
    localparam int IDX_CTL = 2;

    localparam int SET_OFS = 4;
    localparam int CLR_OFS = 8;

    // control bit positions
    localparam int B_SRST        = 31;
    localparam int B_CLKGATE     = 30;
    localparam int B_AUTO_USBCLK = 26;
    localparam int B_AUTO_CLRUG  = 25;
    localparam int B_WAKE_VBUS   = 23;
    localparam int B_WAKE_ID     = 22;
    localparam int B_WAKE_LINE   = 21;
    localparam int B_AUTO_CLRPWD = 20;
    localparam int B_AUTO_CLRCG  = 19;
    localparam int B_AUTO_PLL    = 18;
    localparam int B_LS_LEVEL    = 15;
    localparam int B_FS_LEVEL    = 14;
    localparam int B_HOST_DISC   = 1;

    // transmit trim field low bits
    localparam int TX_P_LSB = 16;
    localparam int TX_N_LSB = 8;
    localparam int TX_D_LSB = 0;
    localparam int TRIM_W   = 4;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PLAIN,
        OP_SET,
        OP_CLR
    } wr_op_e;

    function automatic logic [7:0] reg_base(input int idx);
        case (idx)
            IDX_PWD: return 8'h00;
            IDX_TX:  return 8'h10;
            default: return 8'h30;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        case (idx)
            IDX_PWD: m = '1;
            IDX_TX: begin
                m[TX_P_LSB +: TRIM_W] = '1;
                m[TX_N_LSB +: TRIM_W] = '1;
                m[TX_D_LSB +: TRIM_W] = '1;
            end
            default: begin
                m[B_SRST]        = 1'b1;
                m[B_CLKGATE]     = 1'b1;
                m[B_AUTO_USBCLK] = 1'b1;
                m[B_AUTO_CLRUG]  = 1'b1;
                m[B_WAKE_VBUS]   = 1'b1;
                m[B_WAKE_ID]     = 1'b1;
                m[B_WAKE_LINE]   = 1'b1;
                m[B_AUTO_CLRPWD] = 1'b1;
                m[B_AUTO_CLRCG]  = 1'b1;
                m[B_AUTO_PLL]    = 1'b1;
                m[B_LS_LEVEL]    = 1'b1;
                m[B_FS_LEVEL]    = 1'b1;
                m[B_HOST_DISC]   = 1'b1;
            end
        endcase
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] reg_rst(input int idx);
        logic [DATA_W-1:0] r;
        r = '0;
        case (idx)
            IDX_PWD: r = '1;
            IDX_TX:  r = '0;
            default: r[B_CLKGATE] = 1'b1;
        endcase
        return r;
    endfunction

    // bits that survive the soft reset hold (only the soft reset bit itself)
    function automatic logic [DATA_W-1:0] reg_keep(input int idx);
        logic [DATA_W-1:0] k;
        k = '0;
        if (idx == IDX_CTL) k[B_SRST] = 1'b1;
        return k;
    endfunction

endpackage

// File: rtl/usbphy_reg_decode.sv
module usbphy_reg_decode
    import usbphy_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NUM_REGS-1:0] wr_sel,
    output wr_op_e            wr_op,
    output logic [NUM_REGS-1:0] rd_hit
);

    logic [NUM_REGS-1:0] hit_plain;
    logic [NUM_REGS-1:0] hit_set;
    logic [NUM_REGS-1:0] hit_clr;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_match
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(reg_base(g));
        assign hit_plain[g] = (addr == BASE);
        assign hit_set[g]   = (addr == BASE + ADDR_W'(SET_OFS));
        assign hit_clr[g]   = (addr == BASE + ADDR_W'(CLR_OFS));
    end

    always_comb begin
        wr_sel = '0;
        wr_op  = OP_IDLE;
        if (wr) begin
            wr_sel = hit_plain | hit_set | hit_clr;
            if (|hit_plain)    wr_op = OP_PLAIN;
            else if (|hit_set) wr_op = OP_SET;
            else if (|hit_clr) wr_op = OP_CLR;
        end
    end

    assign rd_hit = hit_plain;

endmodule

// File: rtl/usbphy_reg_cell.sv
module usbphy_reg_cell
    import usbphy_regbank_pkg::*;
#(
    parameter int              W    = 32,
    parameter logic [W-1:0]    RST  = '0,
    parameter logic [W-1:0]    MASK = '1,
    parameter logic [W-1:0]    KEEP = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  wr_op_e       op,
    input  logic [W-1:0] wdata,
    input  logic         hold,
    output logic         keep_o,
    output logic [W-1:0] q_o
);

    logic [W-1:0] upd;
    logic [W-1:0] val_d;
    logic [W-1:0] val_q;

    always_comb begin
        upd = val_q;
        if (sel) begin
            case (op)
                OP_PLAIN: upd = wdata & MASK;
                OP_SET:   upd = val_q | (wdata & MASK);
                OP_CLR:   upd = val_q & ~wdata;
                default:  upd = val_q;
            endcase
        end
        if (hold) val_d = (upd & KEEP) | (RST & ~KEEP);
        else      val_d = upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST;
        else        val_q <= val_d;
    end

    assign keep_o = |(upd & KEEP);
    assign q_o    = val_q;

endmodule

// File: rtl/usbphy_regbank.sv
module usbphy_regbank
    import usbphy_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [31:0]       pwr_down_o,
    output logic [3:0]        tx_term_p_o,
    output logic [3:0]        tx_term_n_o,
    output logic [3:0]        tx_drive_o,
    output logic              ctl_soft_reset_o,
    output logic              ctl_clk_gate_o,
    output logic              ctl_auto_usbclk_o,
    output logic              ctl_auto_clr_usbgate_o,
    output logic              ctl_wake_vbus_o,
    output logic              ctl_wake_id_o,
    output logic              ctl_wake_line_o,
    output logic              ctl_auto_clr_pwd_o,
    output logic              ctl_auto_clr_gate_o,
    output logic              ctl_auto_pll_on_o,
    output logic              ctl_ls_level_o,
    output logic              ctl_fs_level_o,
    output logic              ctl_host_disc_o
);

    logic [NUM_REGS-1:0] wr_sel;
    logic [NUM_REGS-1:0] rd_hit;
    wr_op_e              wr_op;
    logic [NUM_REGS-1:0] keep_v;
    logic [DATA_W-1:0]   q_v [NUM_REGS];
    logic                bank_hold;

    usbphy_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wr_sel (wr_sel),
        .wr_op  (wr_op),
        .rd_hit (rd_hit)
    );

    // next soft reset value decides whether the bank is held this edge
    assign bank_hold = |keep_v;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        usbphy_reg_cell #(
            .W    (DATA_W),
            .RST  (reg_rst(g)),
            .MASK (reg_mask(g)),
            .KEEP (reg_keep(g))
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (wr_sel[g]),
            .op     (wr_op),
            .wdata  (bus_wdata),
            .hold   (bank_hold),
            .keep_o (keep_v[g]),
            .q_o    (q_v[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_hit[i]) bus_rdata = q_v[i];
        end
    end

    assign pwr_down_o  = q_v[IDX_PWD];
    assign tx_term_p_o = q_v[IDX_TX][TX_P_LSB +: TRIM_W];
    assign tx_term_n_o = q_v[IDX_TX][TX_N_LSB +: TRIM_W];
    assign tx_drive_o  = q_v[IDX_TX][TX_D_LSB +: TRIM_W];

    assign ctl_soft_reset_o       = q_v[IDX_CTL][B_SRST];
    assign ctl_clk_gate_o         = q_v[IDX_CTL][B_CLKGATE];
    assign ctl_auto_usbclk_o      = q_v[IDX_CTL][B_AUTO_USBCLK];
    assign ctl_auto_clr_usbgate_o = q_v[IDX_CTL][B_AUTO_CLRUG];
    assign ctl_wake_vbus_o        = q_v[IDX_CTL][B_WAKE_VBUS];
    assign ctl_wake_id_o          = q_v[IDX_CTL][B_WAKE_ID];
    assign ctl_wake_line_o        = q_v[IDX_CTL][B_WAKE_LINE];
    assign ctl_auto_clr_pwd_o     = q_v[IDX_CTL][B_AUTO_CLRPWD];
    assign ctl_auto_clr_gate_o    = q_v[IDX_CTL][B_AUTO_CLRCG];
    assign ctl_auto_pll_on_o      = q_v[IDX_CTL][B_AUTO_PLL];
    assign ctl_ls_level_o         = q_v[IDX_CTL][B_LS_LEVEL];
    assign ctl_fs_level_o         = q_v[IDX_CTL][B_FS_LEVEL];
    assign ctl_host_disc_o        = q_v[IDX_CTL][B_HOST_DISC];

endmodule

// File: rtl/usbphy_regbank_chk.sv
module usbphy_regbank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pwr_down_o,
    input logic [3:0]        tx_term_p_o,
    input logic [3:0]        tx_term_n_o,
    input logic [3:0]        tx_drive_o,
    input logic              ctl_soft_reset_o,
    input logic              ctl_clk_gate_o,
    input logic              ctl_auto_usbclk_o,
    input logic              ctl_auto_clr_usbgate_o,
    input logic              ctl_wake_vbus_o,
    input logic              ctl_wake_id_o,
    input logic              ctl_wake_line_o,
    input logic              ctl_auto_clr_pwd_o,
    input logic              ctl_auto_clr_gate_o,
    input logic              ctl_auto_pll_on_o,
    input logic              ctl_ls_level_o,
    input logic              ctl_fs_level_o,
    input logic              ctl_host_disc_o
);

    localparam logic [31:0] CTL_MASK = 32'hC6FC_C002;

    logic [31:0] ctl_vec;
    logic [11:0] tx_vec;
    logic        is_base;
    logic        is_mapped;

    assign ctl_vec = {ctl_soft_reset_o, ctl_clk_gate_o, 3'b000,
                      ctl_auto_usbclk_o, ctl_auto_clr_usbgate_o, 1'b0,
                      ctl_wake_vbus_o, ctl_wake_id_o, ctl_wake_line_o,
                      ctl_auto_clr_pwd_o, ctl_auto_clr_gate_o, ctl_auto_pll_on_o,
                      2'b00, ctl_ls_level_o, ctl_fs_level_o, 12'h000,
                      ctl_host_disc_o, 1'b0};
    assign tx_vec = {tx_term_p_o, tx_term_n_o, tx_drive_o};

    assign is_base = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h10)) ||
                     (bus_addr == ADDR_W'(8'h30));
    assign is_mapped = is_base ||
                       (bus_addr == ADDR_W'(8'h04)) || (bus_addr == ADDR_W'(8'h08)) ||
                       (bus_addr == ADDR_W'(8'h14)) || (bus_addr == ADDR_W'(8'h18)) ||
                       (bus_addr == ADDR_W'(8'h34)) || (bus_addr == ADDR_W'(8'h38));

    // R3
    a_r3_ctl_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h34) && !bus_wdata[31] && !ctl_soft_reset_o)
        |=> ctl_vec == ($past(ctl_vec) | ($past(bus_wdata) & CTL_MASK)));

    // R4
    a_r4_ctl_clr_andnot: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h38) && !ctl_soft_reset_o)
        |=> ctl_vec == ($past(ctl_vec) & ~$past(bus_wdata)));

    // R5
    a_r5_srst_holds_bank: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_soft_reset_o |-> (pwr_down_o == 32'hFFFF_FFFF && tx_vec == 12'h000 &&
                              ctl_vec == 32'hC000_0000));

    // R10 and R2
    a_r10_pwd_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(8'h00) && !ctl_soft_reset_o)
        |=> pwr_down_o == $past(bus_wdata));

    // R9
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !is_base |-> bus_rdata == 32'h0);

    // R9
    a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !is_mapped)
        |=> ($stable(pwr_down_o) && $stable(tx_vec) && $stable(ctl_vec)));

endmodule

bind usbphy_regbank usbphy_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/usbphy_regbank_test.sv
module usbphy_regbank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pwr_down_o;
    logic [3:0]  tx_term_p_o, tx_term_n_o, tx_drive_o;
    logic ctl_soft_reset_o, ctl_clk_gate_o, ctl_auto_usbclk_o, ctl_auto_clr_usbgate_o;
    logic ctl_wake_vbus_o, ctl_wake_id_o, ctl_wake_line_o, ctl_auto_clr_pwd_o;
    logic ctl_auto_clr_gate_o, ctl_auto_pll_on_o, ctl_ls_level_o, ctl_fs_level_o;
    logic ctl_host_disc_o;

    int n_cmp = 0;
    int n_bad = 0;

    // expected model, derived from the requirements
    localparam logic [31:0] MASKS [3] = '{32'hFFFF_FFFF, 32'h000F_0F0F, 32'hC6FC_C002};
    localparam logic [31:0] RSTS  [3] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h4000_0000};
    localparam logic [7:0]  BASES [3] = '{8'h00, 8'h10, 8'h30};
    logic [31:0] mdl [3];

    always #5 clk = ~clk;

    usbphy_regbank uut (.*);

    task automatic cmp(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] upd [3];
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        for (int i = 0; i < 3; i++) begin
            upd[i] = mdl[i];
            if (a == BASES[i])          upd[i] = d & MASKS[i];
            else if (a == BASES[i] + 4) upd[i] = mdl[i] | (d & MASKS[i]);
            else if (a == BASES[i] + 8) upd[i] = mdl[i] & ~d;
        end
        if (upd[2][31]) begin
            mdl[0] = RSTS[0];
            mdl[1] = RSTS[1];
            mdl[2] = RSTS[2] | 32'h8000_0000;
        end else begin
            for (int i = 0; i < 3; i++) mdl[i] = upd[i];
        end
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        logic [31:0] ctl_out;
        for (int i = 0; i < 3; i++) begin
            rd(BASES[i], d);
            cmp(req, $sformatf("read %02h", BASES[i]), d, mdl[i]);
        end
        cmp("R10", "pwr_down_o", pwr_down_o, mdl[0]);
        cmp("R8", "tx trims", {12'h0, tx_term_p_o, 4'h0, tx_term_n_o, 4'h0, tx_drive_o},
            mdl[1]);
        ctl_out = {ctl_soft_reset_o, ctl_clk_gate_o, 3'b000, ctl_auto_usbclk_o,
                   ctl_auto_clr_usbgate_o, 1'b0, ctl_wake_vbus_o, ctl_wake_id_o,
                   ctl_wake_line_o, ctl_auto_clr_pwd_o, ctl_auto_clr_gate_o,
                   ctl_auto_pll_on_o, 2'b00, ctl_ls_level_o, ctl_fs_level_o, 12'h000,
                   ctl_host_disc_o, 1'b0};
        cmp("R7", "ctl outputs", ctl_out, mdl[2]);
    endtask

    function automatic string tag_for(input int op);
        if (mdl[2][31]) return "R5";
        case (op)
            0: return "R2";
            1: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 3; i++) mdl[i] = RSTS[i];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // walking-one sweeps over every register and every write form
        for (int r = 0; r < 3; r++) begin
            for (int op = 0; op < 3; op++) begin
                if (op == 2) begin
                    wr(BASES[r], 32'hFFFF_FFFF & ~32'h8000_0000);
                    check_all("R2");
                end
                for (int b = 0; b < 32; b++) begin
                    logic [31:0] v;
                    v = 32'h1 << b;
                    wr(BASES[r] + 8'(op * 4), v);
                    check_all(tag_for(op));
                end
            end
        end

        // field-separating patterns
        wr(8'h38, 32'h8000_0000); check_all("R6");
        wr(8'h30, 32'hA5A5_A5A5); check_all("R2");
        wr(8'h10, 32'h5A5A_5A5A); check_all("R8");
        wr(8'h00, 32'hA5A5_5A5A); check_all("R10");
        wr(8'h34, 32'h5A5A_5A5A & ~32'h8000_0000); check_all("R3");
        wr(8'h18, 32'h000F_0000); check_all("R4");

        // soft reset hold and release
        wr(8'h34, 32'h8000_0000); check_all("R5");
        wr(8'h10, 32'h000F_0F0F); check_all("R5");
        wr(8'h04, 32'h0000_FFFF); check_all("R5");
        wr(8'h34, 32'h0000_0002); check_all("R5");
        wr(8'h30, 32'h0004_0002); check_all("R6");
        wr(8'h10, 32'h0003_0201); check_all("R6");

        // unmapped offsets: writes ignored, reads zero
        for (int a = 0; a < 256; a++) begin
            logic mapped;
            mapped = 1'b0;
            for (int i = 0; i < 3; i++)
                if (a == BASES[i] || a == BASES[i] + 4 || a == BASES[i] + 8) mapped = 1'b1;
            if (!mapped) begin
                wr(8'(a), 32'hFFFF_FFFF);
                rd(8'(a), d);
                cmp("R9", $sformatf("read %02h", a), d, 32'h0);
            end else if (a != BASES[0] && a != BASES[1] && a != BASES[2]) begin
                rd(8'(a), d);
                cmp("R9", $sformatf("alias read %02h", a), d, 32'h0);
            end
        end
        check_all("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule